// File: doc/BRIEF.md
# Endian-Selectable Transmit Byte Queue

This block buffers 16-bit words written by a host through a write-only data port and hands them out one byte at a time to a byte-serial transmitter. Each word sits in a queue of parameterised depth. A runtime endian control decides, for each word as it is written, which byte lane leaves first. A single-byte qualifier on the write marks a word that carries only one byte. In big-endian mode that byte sits in the upper lane, and in little-endian mode it sits in the lower lane.

The write side uses a valid/ready pair. `wr_ready` shows whether a word presented on `wr_valid` is stored on the next clock edge. A word that is presented while `wr_ready` is low is dropped. The source does not have to hold it, so the port works as a register write that is lost when the queue is full. The byte side is a normal valid/ready stream. `out_data` is held stable while `out_valid` is high and `out_ready` is low, and a byte leaves on a cycle where both are high.

Empty and full flags report the queue state. A request flag tells a DMA engine that words are wanted. It is computed whether or not the request enable is set, and only the outgoing request line is gated by the enable. An asynchronous power-on reset and a synchronous soft-reset input both clear the stored words, the pointers and the byte phase.

Top module: `tx_word_fifo`

## Requirements
- R1: After power-on reset, and on the cycle after `soft_rst` is high, `tx_empty`=1, `tx_full`=0 and `out_valid`=0. Words and partly sent bytes held before that are discarded.
- R2: With `little_end`=0 at write time and `wr_single`=0, the word leaves as two bytes: bits 15:8 first, then bits 7:0.
- R3: With `little_end`=1 at write time and `wr_single`=0, the word leaves as two bytes: bits 7:0 first, then bits 15:8.
- R4: With `little_end`=0 and `wr_single`=1, exactly one byte leaves, taken from bits 15:8.
- R5: With `little_end`=1 and `wr_single`=1, exactly one byte leaves, taken from bits 7:0.
- R6: After DEPTH words are accepted and none are drained, `tx_full`=1 and `wr_ready`=0. A word written in that state is not stored, and draining returns exactly the DEPTH accepted words in order.
- R7: `tx_empty` is 1 exactly when no byte is pending. It stays 0 until the last byte of the last word has left, and `out_valid` is its inverse.
- R8: Byte order and lane choice are fixed when a word is written. A later change of `little_end` does not alter words already queued. Words leave in the order they were written.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` stay unchanged on the next cycle.
- R10: `drq_status` is 1 when `cmd_wr_active`=1 and `tx_full`=0, and it does not depend on `drq_en`. `drq_req` equals `drq_status` AND `drq_en`.
- R11: After a soft reset in the middle of a word, the next word written starts from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous clear of the queue and the byte phase |
| little_end | input | 1 | 0 = big-endian, 1 = little-endian; sampled when a word is written |
| wr_valid | input | 1 | Host presents a word |
| wr_ready | output | 1 | The word is stored this edge; low when full or in soft reset |
| wr_data | input | 16 | Written word |
| wr_single | input | 1 | Word carries a single byte in the endian-selected lane |
| out_valid | output | 1 | A byte is available |
| out_ready | input | 1 | Transmitter takes the byte |
| out_data | output | 8 | Current byte |
| tx_empty | output | 1 | No byte pending |
| tx_full | output | 1 | DEPTH words stored |
| cmd_wr_active | input | 1 | A write command is in progress |
| drq_en | input | 1 | Enable for the outgoing request line |
| drq_status | output | 1 | Request condition, independent of `drq_en` |
| drq_req | output | 1 | Gated request to the DMA engine |

## Verification
The bench builds the block with its default DEPTH of 8. This is small enough to fill the queue with a few writes, so the full boundary, the dropped write and the wrap of both pointers during the drain can all be reached. The vector table covers all four combinations of endian mode and single-byte qualifier with distinct lane patterns, so a swapped lane shows up. The directed tests cover a soft reset between the two bytes of a word and an endian change while words are queued.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int TXF_BYTE_W = 8;
  localparam int TXF_WORD_W = 2 * TXF_BYTE_W;

  // One queued word, already arranged into transmit order.
  typedef struct packed {
    logic                  single;
    logic [TXF_BYTE_W-1:0] first;
    logic [TXF_BYTE_W-1:0] second;
  } txf_entry_t;
endpackage

// File: rtl/txf_lane_order.sv
module txf_lane_order
  import txf_pkg::*;
(
  input  logic [TXF_WORD_W-1:0] word,
  input  logic                  little,
  input  logic                  single,
  output txf_entry_t            entry
);
  logic [TXF_BYTE_W-1:0] hi_lane;
  logic [TXF_BYTE_W-1:0] lo_lane;

  assign hi_lane = word[TXF_WORD_W-1:TXF_BYTE_W];
  assign lo_lane = word[TXF_BYTE_W-1:0];

  // A lone byte always leaves as "first", so lane choice and order agree.
  always_comb begin
    entry.single = single;
    if (little) begin
      entry.first  = lo_lane;
      entry.second = hi_lane;
    end else begin
      entry.first  = hi_lane;
      entry.second = lo_lane;
    end
  end
endmodule

// File: rtl/txf_store.sv
module txf_store
  import txf_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       push,
  input  txf_entry_t push_entry,
  input  logic       pop,
  output txf_entry_t head,
  output logic [CW-1:0] count
);
  txf_entry_t    mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  assign head = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wptr] <= push_entry;
        wptr      <= ptr_inc(wptr);
      end
      if (pop) rptr <= ptr_inc(rptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/txf_byte_unpack.sv
module txf_byte_unpack
  import txf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  have_word,
  input  txf_entry_t            head,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [TXF_BYTE_W-1:0] out_data,
  output logic                  pop
);
  logic on_second;
  logic fire;
  logic last_byte;

  assign out_valid = have_word;
  assign out_data  = on_second ? head.second : head.first;
  assign fire      = out_valid && out_ready;
  assign last_byte = head.single || on_second;
  assign pop       = fire && last_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     on_second <= 1'b0;
    else if (clr)   on_second <= 1'b0;
    else if (fire)  on_second <= !last_byte;
  end
endmodule

// File: rtl/tx_word_fifo.sv
module tx_word_fifo
  import txf_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  little_end,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [TXF_WORD_W-1:0] wr_data,
  input  logic                  wr_single,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [TXF_BYTE_W-1:0] out_data,
  output logic                  tx_empty,
  output logic                  tx_full,
  input  logic                  cmd_wr_active,
  input  logic                  drq_en,
  output logic                  drq_status,
  output logic                  drq_req
);
  txf_entry_t    in_entry;
  txf_entry_t    head;
  logic [CW-1:0] count;
  logic          push;
  logic          pop;
  logic          have_word;

  txf_lane_order u_order (
    .word   (wr_data),
    .little (little_end),
    .single (wr_single),
    .entry  (in_entry)
  );

  txf_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_rst),
    .push       (push),
    .push_entry (in_entry),
    .pop        (pop),
    .head       (head),
    .count      (count)
  );

  txf_byte_unpack u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_rst),
    .have_word (have_word),
    .head      (head),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .pop       (pop)
  );

  assign have_word  = (count != '0);
  assign tx_full    = (count == CW'(DEPTH));
  assign tx_empty   = !have_word;
  assign wr_ready   = !tx_full && !soft_rst;
  assign push       = wr_valid && wr_ready;
  assign drq_status = cmd_wr_active && !tx_full;
  assign drq_req    = drq_status && drq_en;
endmodule

// File: rtl/txf_checker.sv
module txf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       wr_ready,
  input logic       tx_full,
  input logic       tx_empty,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       drq_status,
  input logic       drq_req
);
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_empty && !tx_full && !out_valid)); // R1

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !wr_ready); // R6

  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty)); // R6

  AST_EMPTY_MATCHES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty != out_valid); // R7

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !soft_rst) |=> (out_valid && $stable(out_data))); // R9

  AST_REQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    drq_req |-> drq_status); // R10
endmodule

bind tx_word_fifo txf_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .wr_ready   (wr_ready),
  .tx_full    (tx_full),
  .tx_empty   (tx_empty),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .drq_status (drq_status),
  .drq_req    (drq_req)
);

// File: tb/tb_tx_word_fifo.sv
module tb_tx_word_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int NVEC       = 8;

  // {little, single, word, first byte, second byte}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 16'h1234, 8'h12, 8'h34},
    {1'b1, 1'b0, 16'h1234, 8'h34, 8'h12},
    {1'b0, 1'b1, 16'hABCD, 8'hAB, 8'h00},
    {1'b1, 1'b1, 16'hABCD, 8'hCD, 8'h00},
    {1'b0, 1'b0, 16'h00FF, 8'h00, 8'hFF},
    {1'b1, 1'b0, 16'h8001, 8'h01, 8'h80},
    {1'b0, 1'b1, 16'h5A00, 8'h5A, 8'h00},
    {1'b1, 1'b1, 16'h00C3, 8'hC3, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        little_end = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic        wr_single = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        tx_empty;
  logic        tx_full;
  logic        cmd_wr_active = 1'b0;
  logic        drq_en = 1'b0;
  logic        drq_status;
  logic        drq_req;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tx_word_fifo #(.DEPTH(DEPTH)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .little_end    (little_end),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_data       (wr_data),
    .wr_single     (wr_single),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .tx_empty      (tx_empty),
    .tx_full       (tx_full),
    .cmd_wr_active (cmd_wr_active),
    .drq_en        (drq_en),
    .drq_status    (drq_status),
    .drq_req       (drq_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic push_word(input logic l, input logic s, input logic [15:0] d);
    little_end = l;
    wr_single  = s;
    wr_data    = d;
    wr_valid   = 1'b1;
    @(negedge clk);
    wr_valid   = 1'b0;
    wr_single  = 1'b0;
  endtask

  task automatic pull_byte(output logic v, output logic [7:0] b);
    v = out_valid;
    b = out_data;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic pulse_soft;
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic       v;
    logic [7:0] b;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: state after power-on reset
    chk("R1 empty after reset", 16'(tx_empty), 16'h1);
    chk("R1 full after reset", 16'(tx_full), 16'h0);
    chk("R1 valid after reset", 16'(out_valid), 16'h0);

    // Table walk: R2 R3 R4 R5, one word at a time
    for (int i = 0; i < NVEC; i++) begin
      push_word(VEC[i][33], VEC[i][32], VEC[i][31:16]);
      pull_byte(v, b);
      chk($sformatf("R2/R3/R4/R5 vec%0d first valid", i), 16'(v), 16'h1);
      chk($sformatf("R2/R3/R4/R5 vec%0d first byte", i), 16'(b), 16'(VEC[i][15:8]));
      if (!VEC[i][32]) begin
        chk($sformatf("R7 vec%0d pending after first", i), 16'(tx_empty), 16'h0);
        pull_byte(v, b);
        chk($sformatf("R2/R3 vec%0d second byte", i), 16'(b), 16'(VEC[i][7:0]));
      end
      chk($sformatf("R4/R5/R7 vec%0d empty after word", i), 16'(tx_empty), 16'h1);
    end

    // R6: fill, drop a write while full, drain in order (pointers wrap)
    push_word(1'b0, 1'b0, 16'h7777);
    pull_byte(v, b);
    pull_byte(v, b);
    for (int i = 0; i < DEPTH; i++) push_word(1'b0, 1'b0, {8'(i + 1), 8'(i + 8'h10)});
    chk("R6 full flag", 16'(tx_full), 16'h1);
    chk("R6 ready low", 16'(wr_ready), 16'h0);
    push_word(1'b0, 1'b0, 16'hDEAD);
    chk("R6 still full", 16'(tx_full), 16'h1);
    for (int i = 0; i < DEPTH; i++) begin
      pull_byte(v, b);
      chk($sformatf("R6/R8 word%0d hi", i), 16'(b), 16'(i + 1));
      pull_byte(v, b);
      chk($sformatf("R6/R8 word%0d lo", i), 16'(b), 16'(i + 8'h10));
    end
    chk("R6 dropped write absent", 16'(tx_empty), 16'h1);

    // R8: endian change after a word is queued
    push_word(1'b0, 1'b0, 16'h1234);
    little_end = 1'b1;
    pull_byte(v, b);
    chk("R8 kept big-endian first", 16'(b), 16'h12);
    pull_byte(v, b);
    chk("R8 kept big-endian second", 16'(b), 16'h34);

    // R9: back-pressure holds the byte
    push_word(1'b1, 1'b0, 16'hC0DE);
    repeat (3) @(negedge clk);
    chk("R9 valid held", 16'(out_valid), 16'h1);
    chk("R9 data held", 16'(out_data), 16'hDE);
    pull_byte(v, b);
    pull_byte(v, b);
    chk("R9 second after hold", 16'(b), 16'hC0);

    // R10: request status independent of enable
    cmd_wr_active = 1'b1;
    drq_en = 1'b0;
    #1;
    chk("R10 status with enable off", 16'(drq_status), 16'h1);
    chk("R10 req gated off", 16'(drq_req), 16'h0);
    drq_en = 1'b1;
    #1;
    chk("R10 req with enable on", 16'(drq_req), 16'h1);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) push_word(1'b0, 1'b0, 16'h0101);
    chk("R10 status drops when full", 16'(drq_status), 16'h0);
    cmd_wr_active = 1'b0;
    drq_en = 1'b0;

    // R1 R11: soft reset in the middle of a word
    pulse_soft();
    chk("R1 soft reset empty", 16'(tx_empty), 16'h1);
    chk("R1 soft reset not full", 16'(tx_full), 16'h0);
    push_word(1'b0, 1'b0, 16'hA1B2);
    pull_byte(v, b);
    pulse_soft();
    chk("R11 empty after mid-word clear", 16'(tx_empty), 16'h1);
    push_word(1'b1, 1'b0, 16'h4455);
    pull_byte(v, b);
    chk("R11 restarts at first byte", 16'(b), 16'h55);
    pull_byte(v, b);
    chk("R11 second byte", 16'(b), 16'h44);
    chk("R7 empty at end", 16'(tx_empty), 16'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule